// File: doc/BRIEF.md
# Panel Timing Generator

This block produces the raster timing for a parallel RGB panel. Software programs the timing values: line length, hsync width, the wait from the end of hsync to the first pixel, pixels per line, frame length in lines, vsync width in lines, the wait in lines from the end of vsync to the first active line, and active lines per frame. From these the block drives horizontal sync, vertical sync and data-enable. It also gives a pixel request strobe for the pixel fetch logic, a one-cycle frame-done pulse, and a registered select for the dot-clock edge.

A line begins with its hsync pulse. The horizontal wait follows, then the active pixels, then any remaining clocks up to the programmed line length. A frame is built the same way from lines. Hsync, vsync and data-enable each have their own polarity bit. A separate bit turns the data-enable output on or off. A sync-enable input starts and stops the raster. While it is low, every sync output sits at its inactive level. When it rises, the raster starts again from line 0, clock 0.

Top module: `panelTimingGen`

## Requirements
- R1: Each line lasts `linePeriod` clocks (a value of 0 counts as 1). Horizontal sync is active during the first `hsyncWidth` clocks of every line.
- R2: Horizontal activity is asserted for `activePixels` clocks. It starts at clock `hsyncWidth + hWait` of the line and applies only on active lines. `pixelReq` is 1 exactly on those clocks.
- R3: Each frame lasts `frameLines` lines (0 counts as 1). Vertical sync is active during the first `vsyncWidth` lines of the frame.
- R4: The active lines are lines `vsyncWidth + vWait` through `vsyncWidth + vWait + activeLines - 1`.
- R5: Each of `hsyncOut`, `vsyncOut` and `deOut` is high while active when its polarity bit is 1. It is low while active when its polarity bit is 0.
- R6: With `dePresent` at 0, `deOut` stays at its inactive level. `pixelReq` is not affected.
- R7: While `syncEn` is low, hsync, vsync and data-enable sit at their inactive levels, and `pixelReq` and `frameDone` are 0. The raster position shown on the outputs one clock after `syncEn` is first sampled high is line 0, clock 0. Each later clock shows the next position.
- R8: `frameDone` is a single-cycle pulse. It appears on the clock after the cycle that shows the last active pixel of the last active line.
- R9: `dotClkEdge` follows `dotClkFalling` one clock later (1 selects the falling edge).
- R10: While reset is asserted, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Active-low synchronous reset |
| syncEn | input | 1 | Runs the raster; low holds outputs inactive |
| linePeriod | input | H_W | Total clocks per line |
| hsyncWidth | input | HSW_W | Hsync pulse length in clocks |
| hWait | input | HWAIT_W | Clocks from end of hsync to first pixel |
| activePixels | input | HACT_W | Active pixels per line |
| frameLines | input | V_W | Total lines per frame |
| vsyncWidth | input | VSW_W | Vsync pulse length in lines |
| vWait | input | VWAIT_W | Lines from end of vsync to first active line |
| activeLines | input | VACT_W | Active lines per frame |
| hsyncPolHigh | input | 1 | Hsync active-high when 1 |
| vsyncPolHigh | input | 1 | Vsync active-high when 1 |
| dePolHigh | input | 1 | Data-enable active-high when 1 |
| dePresent | input | 1 | Enables the data-enable output |
| dotClkFalling | input | 1 | Requests falling-edge data launch |
| hsyncOut | output | 1 | Horizontal sync |
| vsyncOut | output | 1 | Vertical sync |
| deOut | output | 1 | Data-enable |
| pixelReq | output | 1 | Active-high pixel request, one per active pixel |
| frameDone | output | 1 | One-cycle end-of-frame pulse |
| dotClkEdge | output | 1 | Registered dot-clock edge select |

## Verification
The bench builds the block with narrow fields: an 8-bit line length, a 6-bit frame length and 4- to 7-bit sync, wait and active counts. With these widths a whole frame takes a few hundred clocks, so several complete frames per configuration fit easily. Random configurations at these widths reach zero porches and a zero horizontal wait. They also reach active regions that end on the last clock of a line and on the last line of a frame. Under those widths a bench model predicts every output on every clock through two frames and through a stop and restart.

// File: rtl/lcdTimingPkg.sv
package lcdTimingPkg;

  // Per-cycle raster strobes passed from the counters to the output stage
  typedef struct packed {
    logic run;      // raster enabled this cycle
    logic hsAct;    // inside horizontal sync
    logic vsAct;    // inside vertical sync
    logic deAct;    // inside active pixel window
    logic lastPix;  // last active pixel of the frame
  } tmgStrobe_t;

endpackage

// File: rtl/lcdTimingCtrl.sv
module lcdTimingCtrl
  import lcdTimingPkg::*;
#(
  parameter int H_W     = 18,
  parameter int HSW_W   = 14,
  parameter int HWAIT_W = 12,
  parameter int HACT_W  = 18,
  parameter int V_W     = 16,
  parameter int VSW_W   = 18,
  parameter int VWAIT_W = 16,
  parameter int VACT_W  = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               syncEn,
  input  logic [H_W-1:0]     linePeriod,
  input  logic [HSW_W-1:0]   hsyncWidth,
  input  logic [HWAIT_W-1:0] hWait,
  input  logic [HACT_W-1:0]  activePixels,
  input  logic [V_W-1:0]     frameLines,
  input  logic [VSW_W-1:0]   vsyncWidth,
  input  logic [VWAIT_W-1:0] vWait,
  input  logic [VACT_W-1:0]  activeLines,
  output tmgStrobe_t         strobe
);

  localparam int HM1    = (HSW_W > HWAIT_W) ? HSW_W : HWAIT_W;
  localparam int HM2    = (HM1 > HACT_W) ? HM1 : HACT_W;
  localparam int HM3    = (HM2 > H_W) ? HM2 : H_W;
  localparam int HSUM_W = HM3 + 2;
  localparam int VM1    = (VSW_W > VWAIT_W) ? VSW_W : VWAIT_W;
  localparam int VM2    = (VM1 > VACT_W) ? VM1 : VACT_W;
  localparam int VM3    = (VM2 > V_W) ? VM2 : V_W;
  localparam int VSUM_W = VM3 + 2;

  logic [H_W-1:0] hCnt;
  logic [V_W-1:0] vCnt;

  logic [HSUM_W-1:0] hPos, hLen, hActStart, hActEnd;
  logic [VSUM_W-1:0] vPos, vLen, vActStart, vActEnd;
  logic lineEnd, frameEnd, hWin, vWin;

  always_comb begin
    hPos      = HSUM_W'(hCnt);
    hLen      = (linePeriod == '0) ? HSUM_W'(1) : HSUM_W'(linePeriod);
    hActStart = HSUM_W'(hsyncWidth) + HSUM_W'(hWait);
    hActEnd   = hActStart + HSUM_W'(activePixels);
    vPos      = VSUM_W'(vCnt);
    vLen      = (frameLines == '0) ? VSUM_W'(1) : VSUM_W'(frameLines);
    vActStart = VSUM_W'(vsyncWidth) + VSUM_W'(vWait);
    vActEnd   = vActStart + VSUM_W'(activeLines);

    lineEnd   = (hPos + HSUM_W'(1)) >= hLen;
    frameEnd  = lineEnd && ((vPos + VSUM_W'(1)) >= vLen);
    hWin      = (hPos >= hActStart) && (hPos < hActEnd);
    vWin      = (vPos >= vActStart) && (vPos < vActEnd);

    strobe.run     = syncEn;
    strobe.hsAct   = hPos < HSUM_W'(hsyncWidth);
    strobe.vsAct   = vPos < VSUM_W'(vsyncWidth);
    strobe.deAct   = hWin && vWin;
    strobe.lastPix = hWin && vWin &&
                     (hPos == hActEnd - HSUM_W'(1)) &&
                     (vPos == vActEnd - VSUM_W'(1));
  end

  always_ff @(posedge clk) begin
    if (!rstN || !syncEn) begin
      hCnt <= '0;
      vCnt <= '0;
    end else if (lineEnd) begin
      hCnt <= '0;
      vCnt <= frameEnd ? '0 : vCnt + V_W'(1);
    end else begin
      hCnt <= hCnt + H_W'(1);
    end
  end

  // R3
  vline_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(vCnt) |-> (hCnt == '0))
    else $error("line counter moved away from a line boundary");

  // R1
  line_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (syncEn && lineEnd) |=> (hCnt == '0))
    else $error("clock counter did not wrap at line end");

endmodule

// File: rtl/lcdSyncOut.sv
module lcdSyncOut
  import lcdTimingPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  tmgStrobe_t strobe,
  input  logic       hsyncPolHigh,
  input  logic       vsyncPolHigh,
  input  logic       dePolHigh,
  input  logic       dePresent,
  input  logic       dotClkFalling,
  output logic       hsyncOut,
  output logic       vsyncOut,
  output logic       deOut,
  output logic       pixelReq,
  output logic       frameDone,
  output logic       dotClkEdge
);

  logic hsActQ, deActQ, lastQ;
  logic hsAct, vsAct, deAct;

  always_comb begin
    hsAct = strobe.run && strobe.hsAct;
    vsAct = strobe.run && strobe.vsAct;
    deAct = strobe.run && strobe.deAct;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hsyncOut   <= 1'b0;
      vsyncOut   <= 1'b0;
      deOut      <= 1'b0;
      pixelReq   <= 1'b0;
      frameDone  <= 1'b0;
      dotClkEdge <= 1'b0;
      hsActQ     <= 1'b0;
      deActQ     <= 1'b0;
      lastQ      <= 1'b0;
    end else begin
      // an active level equals the polarity bit; inactive is its inverse
      hsyncOut   <= hsAct ~^ hsyncPolHigh;
      vsyncOut   <= vsAct ~^ vsyncPolHigh;
      deOut      <= (deAct && dePresent) ~^ dePolHigh;
      pixelReq   <= deAct;
      lastQ      <= strobe.run && strobe.lastPix;
      frameDone  <= strobe.run && lastQ;
      dotClkEdge <= dotClkFalling;
      hsActQ     <= hsAct;
      deActQ     <= deAct;
    end
  end

  // R2
  de_outside_hsync_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(hsActQ && deActQ))
    else $error("data-enable overlapped horizontal sync");

  // R8
  frame_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |=> !frameDone)
    else $error("frame-done wider than one cycle");

  // R8
  done_after_pixel_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |-> $past(pixelReq))
    else $error("frame-done without a preceding pixel");

  // R7
  idle_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !$past(strobe.run)) |->
      (hsyncOut != $past(hsyncPolHigh) && vsyncOut != $past(vsyncPolHigh) &&
       deOut != $past(dePolHigh) && !pixelReq))
    else $error("outputs not idle while disabled");

endmodule

// File: rtl/panelTimingGen.sv
module panelTimingGen
  import lcdTimingPkg::*;
#(
  parameter int H_W     = 18,
  parameter int HSW_W   = 14,
  parameter int HWAIT_W = 12,
  parameter int HACT_W  = 18,
  parameter int V_W     = 16,
  parameter int VSW_W   = 18,
  parameter int VWAIT_W = 16,
  parameter int VACT_W  = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               syncEn,
  input  logic [H_W-1:0]     linePeriod,
  input  logic [HSW_W-1:0]   hsyncWidth,
  input  logic [HWAIT_W-1:0] hWait,
  input  logic [HACT_W-1:0]  activePixels,
  input  logic [V_W-1:0]     frameLines,
  input  logic [VSW_W-1:0]   vsyncWidth,
  input  logic [VWAIT_W-1:0] vWait,
  input  logic [VACT_W-1:0]  activeLines,
  input  logic               hsyncPolHigh,
  input  logic               vsyncPolHigh,
  input  logic               dePolHigh,
  input  logic               dePresent,
  input  logic               dotClkFalling,
  output logic               hsyncOut,
  output logic               vsyncOut,
  output logic               deOut,
  output logic               pixelReq,
  output logic               frameDone,
  output logic               dotClkEdge
);

  tmgStrobe_t strobe;

  lcdTimingCtrl #(
    .H_W(H_W), .HSW_W(HSW_W), .HWAIT_W(HWAIT_W), .HACT_W(HACT_W),
    .V_W(V_W), .VSW_W(VSW_W), .VWAIT_W(VWAIT_W), .VACT_W(VACT_W)
  ) ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .syncEn       (syncEn),
    .linePeriod   (linePeriod),
    .hsyncWidth   (hsyncWidth),
    .hWait        (hWait),
    .activePixels (activePixels),
    .frameLines   (frameLines),
    .vsyncWidth   (vsyncWidth),
    .vWait        (vWait),
    .activeLines  (activeLines),
    .strobe       (strobe)
  );

  lcdSyncOut outStage (
    .clk           (clk),
    .rstN          (rstN),
    .strobe        (strobe),
    .hsyncPolHigh  (hsyncPolHigh),
    .vsyncPolHigh  (vsyncPolHigh),
    .dePolHigh     (dePolHigh),
    .dePresent     (dePresent),
    .dotClkFalling (dotClkFalling),
    .hsyncOut      (hsyncOut),
    .vsyncOut      (vsyncOut),
    .deOut         (deOut),
    .pixelReq      (pixelReq),
    .frameDone     (frameDone),
    .dotClkEdge    (dotClkEdge)
  );

endmodule

// File: tb/panelTimingGen_test.sv
`timescale 1ns/1ps
module panelTimingGen_test;

  localparam int H_W = 8, HSW_W = 5, HWAIT_W = 5, HACT_W = 7;
  localparam int V_W = 6, VSW_W = 4, VWAIT_W = 4, VACT_W = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic syncEn = 1'b0;
  logic [H_W-1:0]     linePeriod = '0;
  logic [HSW_W-1:0]   hsyncWidth = '0;
  logic [HWAIT_W-1:0] hWait = '0;
  logic [HACT_W-1:0]  activePixels = '0;
  logic [V_W-1:0]     frameLines = '0;
  logic [VSW_W-1:0]   vsyncWidth = '0;
  logic [VWAIT_W-1:0] vWait = '0;
  logic [VACT_W-1:0]  activeLines = '0;
  logic hsyncPolHigh = 1'b1, vsyncPolHigh = 1'b1, dePolHigh = 1'b1;
  logic dePresent = 1'b1, dotClkFalling = 1'b0;
  logic hsyncOut, vsyncOut, deOut, pixelReq, frameDone, dotClkEdge;

  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  panelTimingGen #(
    .H_W(H_W), .HSW_W(HSW_W), .HWAIT_W(HWAIT_W), .HACT_W(HACT_W),
    .V_W(V_W), .VSW_W(VSW_W), .VWAIT_W(VWAIT_W), .VACT_W(VACT_W)
  ) uut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
    end
  endtask

  // bench model of the raster position p (clocks since enable)
  function automatic int hOf(input int p);
    int lp = (linePeriod == 0) ? 1 : int'(linePeriod);
    return p % lp;
  endfunction
  function automatic int lOf(input int p);
    int lp = (linePeriod == 0) ? 1 : int'(linePeriod);
    int fl = (frameLines == 0) ? 1 : int'(frameLines);
    return (p / lp) % fl;
  endfunction
  function automatic bit hsAt(input int p);
    return hOf(p) < int'(hsyncWidth);
  endfunction
  function automatic bit vsAt(input int p);
    return lOf(p) < int'(vsyncWidth);
  endfunction
  function automatic bit actAt(input int p);
    int hs = int'(hsyncWidth) + int'(hWait);
    int vs = int'(vsyncWidth) + int'(vWait);
    return hOf(p) >= hs && hOf(p) < hs + int'(activePixels) &&
           lOf(p) >= vs && lOf(p) < vs + int'(activeLines);
  endfunction
  function automatic bit lastAt(input int p);
    int he = int'(hsyncWidth) + int'(hWait) + int'(activePixels) - 1;
    int ve = int'(vsyncWidth) + int'(vWait) + int'(activeLines) - 1;
    return actAt(p) && hOf(p) == he && lOf(p) == ve;
  endfunction

  task automatic checkIdle();
    chk(hsyncOut == !hsyncPolHigh, "R7 hsync idle", hsyncOut, !hsyncPolHigh);
    chk(vsyncOut == !vsyncPolHigh, "R7 vsync idle", vsyncOut, !vsyncPolHigh);
    chk(deOut == !dePolHigh, "R7 de idle", deOut, !dePolHigh);
    chk(pixelReq == 1'b0, "R7 pixelReq idle", pixelReq, 0);
    chk(frameDone == 1'b0, "R7 frameDone idle", frameDone, 0);
  endtask

  // enable at a falling edge, then compare every slot
  task automatic runRaster(input int slots);
    bit eh, ev, ed, ef;
    syncEn = 1'b1;
    for (int p = 0; p < slots; p++) begin
      @(negedge clk);
      eh = hsAt(p) ~^ hsyncPolHigh;
      ev = vsAt(p) ~^ vsyncPolHigh;
      ed = (actAt(p) && dePresent) ~^ dePolHigh;
      ef = (p > 0) ? lastAt(p - 1) : 1'b0;
      chk(hsyncOut == eh, "R1 R5 hsync", hsyncOut, eh);
      chk(vsyncOut == ev, "R3 R5 vsync", vsyncOut, ev);
      chk(deOut == ed, dePresent ? "R2 R4 R5 de" : "R6 de off", deOut, ed);
      chk(pixelReq == actAt(p), "R2 R4 pixelReq", pixelReq, actAt(p));
      chk(frameDone == ef, "R8 frameDone", frameDone, ef);
      chk(dotClkEdge == dotClkFalling, "R9 dotClkEdge", dotClkEdge, dotClkFalling);
    end
  endtask

  task automatic stopRaster();
    syncEn = 1'b0;
    @(negedge clk);
    checkIdle();
    @(negedge clk);
    checkIdle();
  endtask

  task automatic setCfg(input int lp, hs, hw, act, fl, vs, vw, al);
    linePeriod = H_W'(lp); hsyncWidth = HSW_W'(hs); hWait = HWAIT_W'(hw);
    activePixels = HACT_W'(act); frameLines = V_W'(fl); vsyncWidth = VSW_W'(vs);
    vWait = VWAIT_W'(vw); activeLines = VACT_W'(al);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
    $finish;
  end

  initial begin : main
    int hs, hw, act, vs, vw, al, lp, fl;
    void'($urandom(32'h5eed_1c0d));
    // R10: reset state
    repeat (3) @(negedge clk);
    chk({hsyncOut, vsyncOut, deOut, pixelReq, frameDone, dotClkEdge} == 6'b0,
        "R10 reset outputs", {hsyncOut, vsyncOut, deOut, pixelReq, frameDone, dotClkEdge}, 0);
    rstN = 1'b1;
    @(negedge clk);
    checkIdle();

    // directed: porches everywhere, active-high
    setCfg(16, 2, 3, 8, 9, 1, 2, 4);
    runRaster(2 * 16 * 9 + 5);
    stopRaster();

    // directed: no front porches, active-low, DE output off, falling edge
    setCfg(5, 1, 0, 4, 5, 2, 0, 3);
    hsyncPolHigh = 1'b0; vsyncPolHigh = 1'b0; dePolHigh = 1'b0;
    dePresent = 1'b0; dotClkFalling = 1'b1;
    @(negedge clk);
    checkIdle();
    runRaster(2 * 5 * 5 + 3);
    stopRaster();

    // R7: stop mid-frame then restart from line 0 clock 0
    setCfg(16, 2, 3, 8, 9, 1, 2, 4);
    hsyncPolHigh = 1'b1; vsyncPolHigh = 1'b0; dePolHigh = 1'b1;
    dePresent = 1'b1; dotClkFalling = 1'b0;
    runRaster(61);
    stopRaster();
    runRaster(16 * 9 + 4);
    stopRaster();

    // constrained random configurations
    for (int n = 0; n < 8; n++) begin
      hs  = $urandom_range(1, 6);
      hw  = $urandom_range(0, 5);
      act = $urandom_range(1, 20);
      lp  = hs + hw + act + $urandom_range(0, 4);
      vs  = $urandom_range(1, 3);
      vw  = $urandom_range(0, 3);
      al  = $urandom_range(1, 6);
      fl  = vs + vw + al + $urandom_range(0, 2);
      setCfg(lp, hs, hw, act, fl, vs, vw, al);
      hsyncPolHigh = 1'($urandom); vsyncPolHigh = 1'($urandom);
      dePolHigh = 1'($urandom); dePresent = 1'($urandom);
      dotClkFalling = 1'($urandom);
      @(negedge clk);
      runRaster(2 * lp * fl + 3);
      stopRaster();
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule